// File: doc/BRIEF.md
# Single-Wire Serial Monitor Port

This block is the line interface of a boot or debug monitor that talks to a host over one shared, open data wire. It moves 8-bit characters in both directions, but only one direction at a time. Each character is a low start bit, eight data bits with the least significant first, and a high stop bit. Receive and transmit use one bit rate, which is the input clock divided by a ratio chosen from two strap inputs. The port samples the straps at reset release and keeps the ratio until the next reset. With a 4.9152 MHz clock and the short ratio, or a 9.8304 MHz clock and the long ratio, the rate is 9600 bit/s.

The port drives the wire only while it sends. At all other times it releases the wire so the host can drive it. The host signals a break by holding the wire low from the start bit through the stop-bit position. The port answers by driving the wire high for two bit times and then sending the same all-low pattern back as an echo. Received bytes leave the port with a one-cycle valid pulse. Bytes to send enter through a ready/valid pair that accepts them only while the port is idle.

Top module: `monport_top`

## Requirements
- R1: A transmitted character holds each bit for exactly one bit period: the start bit is 0, then the eight data bits with bit 0 first, then a stop bit of 1. After the stop bit the port releases the wire.
- R2: A character received at the same bit period is delivered on `rxData` together with a `rxValid` pulse that lasts exactly one cycle.
- R3: When both straps are low at reset release, the bit period is DIV_LO clocks. When `selHigh` is high, the bit period is DIV_HI clocks.
- R4: When `hvEntry` is high at reset release, the bit period is DIV_HI clocks whatever `selHigh` is.
- R5: Changing either strap after reset release does not change the bit period.
- R6: When the stop bit is sampled low and all data bits were 0, the port drives the wire high for exactly 2 bit periods. It then drives it low for exactly 10 bit periods and then releases it.
- R7: When the stop bit is sampled low and any data bit was 1, the port raises `rxFrameErr` for one cycle and does not raise `rxValid`.
- R8: `lineOe` is high only while the port is sending or holding the wire high. It is low in reset, while idle and while receiving.
- R9: `txReady` is high only while the port is idle. A `txValid` seen while `txReady` is low is dropped and starts no transmission.
- R10: The start bit is checked again half a bit period after the falling edge. A low pulse shorter than that produces neither `rxValid` nor `rxFrameErr`.
- R11: During and right after reset, `lineOe`, `rxValid` and `rxFrameErr` are 0 and `txReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bit period is derived from it |
| rst_n | input | 1 | Synchronous reset, active low; the straps are sampled while it is low |
| selHigh | input | 1 | Ratio strap: 0 selects DIV_LO, 1 selects DIV_HI |
| hvEntry | input | 1 | Entry-condition strap; when high it forces DIV_HI |
| lineIn | input | 1 | State of the shared wire |
| lineOut | output | 1 | Value driven onto the wire while `lineOe` is high |
| lineOe | output | 1 | Output enable for the wire |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle pulse when a byte is received |
| rxFrameErr | output | 1 | One-cycle pulse on a bad stop bit with nonzero data |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Request to send `txData` |
| txReady | output | 1 | The port is idle and accepts a request |

## Verification
The bench measures the break reply cycle by cycle. A design that shortens the high hold, forgets it, or sends a 9-bit or 11-bit low echo gives the wrong run lengths. A design that treats the break as a framing error gives no reply at all. A framed byte with a low stop bit must raise the error pulse and no valid pulse, so a port that ignores the stop bit shows up at once. Short low glitches test the mid-bit recheck: a receiver without it would clock in a byte of ones, or report a framing error. Strap changes after reset, and resets with each strap combination, expose a ratio that is decoded every cycle instead of latched, or that ignores the forcing input.

// File: rtl/monport_pkg.sv
package monport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_HOLD = 2'd2,
    ST_TX   = 2'd3
  } portState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic armHalf;    // reload timer with half a bit period
    logic armFull;    // reload timer with a full bit period
    logic loadTx;     // load a character frame for sending
    logic loadBreak;  // load the all-low echo frame
    logic shiftRx;    // capture one received data bit
    logic shiftTx;    // advance the transmit frame
    logic stepIdx;    // advance bit index
    logic clrIdx;     // clear bit index
  } ctlStrobe_t;

  localparam int FRAME_BITS = 10;
  localparam int DATA_BITS  = 8;

endpackage

// File: rtl/monport_datapath.sv
module monport_datapath
  import monport_pkg::*;
#(
  parameter int DIV_LO = 512,
  parameter int DIV_HI = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   selHigh,
  input  logic                   hvEntry,
  input  logic                   lineIn,
  input  logic [DATA_BITS-1:0]   txData,
  input  ctlStrobe_t             strobe,
  output logic                   tick,
  output logic                   fall,
  output logic                   lineBit,
  output logic [3:0]             bitIdx,
  output logic [DATA_BITS-1:0]   rxByte,
  output logic                   txBit,
  output logic                   divHigh
);

  localparam int CNT_W = $clog2(DIV_HI) + 1;

  logic [CNT_W-1:0]      bitCnt;
  logic [CNT_W-1:0]      fullM1;
  logic [CNT_W-1:0]      halfM1;
  logic                  syncA;
  logic                  syncB;
  logic                  prevBit;
  logic [FRAME_BITS-1:0] txShift;

  // ratio is captured while reset is held and frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) divHigh <= selHigh | hvEntry;
  end

  assign fullM1 = divHigh ? CNT_W'(DIV_HI - 1)     : CNT_W'(DIV_LO - 1);
  assign halfM1 = divHigh ? CNT_W'(DIV_HI / 2 - 1) : CNT_W'(DIV_LO / 2 - 1);

  // line synchronizer and falling-edge detect
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA   <= 1'b1;
      syncB   <= 1'b1;
      prevBit <= 1'b1;
    end else begin
      syncA   <= lineIn;
      syncB   <= syncA;
      prevBit <= syncB;
    end
  end

  assign lineBit = syncB;
  assign fall    = prevBit & ~syncB;

  // bit timer
  always_ff @(posedge clk) begin
    if (!rst_n)                 bitCnt <= '0;
    else if (strobe.armHalf)    bitCnt <= halfM1;
    else if (strobe.armFull)    bitCnt <= fullM1;
    else if (bitCnt == '0)      bitCnt <= fullM1;
    else                        bitCnt <= bitCnt - 1'b1;
  end

  assign tick = (bitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)               bitIdx <= '0;
    else if (strobe.clrIdx)   bitIdx <= '0;
    else if (strobe.stepIdx)  bitIdx <= bitIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               rxByte <= '0;
    else if (strobe.shiftRx)  rxByte <= {lineBit, rxByte[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 txShift <= '1;
    else if (strobe.loadTx)     txShift <= {1'b1, txData, 1'b0};
    else if (strobe.loadBreak)  txShift <= '0;
    else if (strobe.shiftTx)    txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
  end

  assign txBit = txShift[0];

endmodule

// File: rtl/monport_ctrl.sv
module monport_ctrl
  import monport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 fall,
  input  logic                 lineBit,
  input  logic [3:0]           bitIdx,
  input  logic [DATA_BITS-1:0] rxByte,
  input  logic                 txBit,
  input  logic                 txValid,
  output ctlStrobe_t           strobe,
  output logic                 lineOut,
  output logic                 lineOe,
  output logic                 txReady,
  output logic                 rxValid,
  output logic                 rxFrameErr
);

  localparam logic [3:0] STOP_IDX = 4'(FRAME_BITS - 1);

  portState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState  = state;
    strobe     = '0;
    rxValid    = 1'b0;
    rxFrameErr = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strobe.clrIdx = 1'b1;
        if (txValid) begin
          strobe.loadTx  = 1'b1;
          strobe.armFull = 1'b1;
          nextState      = ST_TX;
        end else if (fall) begin
          strobe.armHalf = 1'b1;
          nextState      = ST_RX;
        end
      end
      ST_RX: begin
        if (tick) begin
          if (bitIdx == '0) begin
            if (lineBit) nextState = ST_IDLE;   // glitch, not a start bit
            else         strobe.stepIdx = 1'b1;
          end else if (bitIdx != STOP_IDX) begin
            strobe.shiftRx = 1'b1;
            strobe.stepIdx = 1'b1;
          end else if (lineBit) begin
            rxValid   = 1'b1;
            nextState = ST_IDLE;
          end else if (rxByte == '0) begin
            strobe.armFull = 1'b1;
            strobe.clrIdx  = 1'b1;
            nextState      = ST_HOLD;
          end else begin
            rxFrameErr = 1'b1;
            nextState  = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (tick) begin
          if (bitIdx == 4'd1) begin
            strobe.loadBreak = 1'b1;
            strobe.clrIdx    = 1'b1;
            nextState        = ST_TX;
          end else begin
            strobe.stepIdx = 1'b1;
          end
        end
      end
      ST_TX: begin
        if (tick) begin
          if (bitIdx == STOP_IDX) begin
            nextState = ST_IDLE;
          end else begin
            strobe.shiftTx = 1'b1;
            strobe.stepIdx = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign lineOe  = (state == ST_TX) || (state == ST_HOLD);
  assign lineOut = (state == ST_TX) ? txBit : 1'b1;
  assign txReady = (state == ST_IDLE);

endmodule

// File: rtl/monport_top.sv
module monport_top
  import monport_pkg::*;
#(
  parameter int DIV_LO = 512,
  parameter int DIV_HI = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       selHigh,
  input  logic       hvEntry,
  input  logic       lineIn,
  output logic       lineOut,
  output logic       lineOe,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       rxFrameErr,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady
);

  ctlStrobe_t strobe;
  logic       tick;
  logic       fall;
  logic       lineBit;
  logic [3:0] bitIdx;
  logic       txBit;
  logic       divHigh;

  monport_datapath #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_dp (
    .clk(clk), .rst_n(rst_n), .selHigh(selHigh), .hvEntry(hvEntry),
    .lineIn(lineIn), .txData(txData), .strobe(strobe), .tick(tick),
    .fall(fall), .lineBit(lineBit), .bitIdx(bitIdx), .rxByte(rxData),
    .txBit(txBit), .divHigh(divHigh)
  );

  monport_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fall(fall), .lineBit(lineBit),
    .bitIdx(bitIdx), .rxByte(rxData), .txBit(txBit), .txValid(txValid),
    .strobe(strobe), .lineOut(lineOut), .lineOe(lineOe), .txReady(txReady),
    .rxValid(rxValid), .rxFrameErr(rxFrameErr)
  );

endmodule

// File: rtl/monport_chk.sv
module monport_chk (
  input logic clk,
  input logic rst_n,
  input logic lineOe,
  input logic lineOut,
  input logic txReady,
  input logic txValid,
  input logic rxValid,
  input logic rxFrameErr,
  input logic divHigh
);

  // R8
  oe_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lineOe |-> !txReady);

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxFrameErr |=> !rxFrameErr);

  // R7
  err_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxFrameErr && rxValid));

  // R1
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txReady) |=> (lineOe && !lineOut));

  // R5
  ratio_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(divHigh));

endmodule

bind monport_top monport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lineOe(lineOe), .lineOut(lineOut),
  .txReady(txReady), .txValid(txValid), .rxValid(rxValid),
  .rxFrameErr(rxFrameErr), .divHigh(divHigh)
);

// File: tb/sim_monport_top.sv
`timescale 1ns/1ps
module sim_monport_top;

  localparam int DL = 16;
  localparam int DH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       selHigh = 1'b0;
  logic       hvEntry = 1'b0;
  logic       extLine = 1'b1;
  logic       lineOut, lineOe, rxValid, rxFrameErr, txReady;
  logic [7:0] rxData;
  logic [7:0] txData = 8'h00;
  logic       txValid = 1'b0;
  logic       bus;

  assign bus = lineOe ? lineOut : extLine;

  monport_top #(.DIV_LO(DL), .DIV_HI(DH)) u0 (
    .clk(clk), .rst_n(rst_n), .selHigh(selHigh), .hvEntry(hvEntry),
    .lineIn(bus), .lineOut(lineOut), .lineOe(lineOe), .rxData(rxData),
    .rxValid(rxValid), .rxFrameErr(rxFrameErr), .txData(txData),
    .txValid(txValid), .txReady(txReady)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  int validCnt = 0;
  int errCnt = 0;
  int oeRxCnt = 0;
  logic [7:0] lastByte = 8'h00;
  bit done = 0;

  // reference observation of received-side events, every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (rxValid) begin
        validCnt++;
        lastByte = rxData;
      end
      if (rxFrameErr) errCnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic sel, input logic hv);
    @(negedge clk);
    rst_n = 1'b0; selHigh = sel; hvEntry = hv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sendChar(input logic [7:0] d, input logic stopBit, input int bl);
    @(negedge clk);
    extLine = 1'b0;
    repeat (bl) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      extLine = d[i];
      repeat (bl) @(negedge clk);
    end
    extLine = stopBit;
    repeat (bl) @(negedge clk);
    extLine = 1'b1;
  endtask

  // issue a request and record the wire, then decode with mid-bit samples
  task automatic txCapture(input logic [7:0] d, input int bl,
                           output logic [7:0] got, output logic stopGot,
                           output int startLen, output logic oeAfter);
    logic wave [0:400];
    @(negedge clk);
    txData = d; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    for (int n = 0; n <= 10 * bl; n++) begin
      wave[n] = lineOe ? lineOut : 1'bz;
      if (n == 10 * bl) oeAfter = lineOe;
      else if (n < 10 * bl) begin end
      if (n < 10 * bl) @(negedge clk);
    end
    startLen = 0;
    for (int n = 0; n < 10 * bl; n++) begin
      if (wave[n] === 1'b0 && startLen == n) startLen++;
    end
    for (int k = 0; k < 8; k++) got[k] = wave[bl / 2 + (k + 1) * bl];
    stopGot = wave[bl / 2 + 9 * bl];
  endtask

  task automatic ratioCheck(input int bl, input string tag);
    logic [7:0] g; logic s; int sl; logic oa;
    txCapture(8'hFF, bl, g, s, sl, oa);
    check(sl == bl, tag, sl, bl);
    repeat (4) @(negedge clk);
  endtask

  task automatic breakWatch(input int bl);
    int holdLen = 0;
    int lowLen = 0;
    int guard = 0;
    while (!lineOe && guard < 40 * bl) begin
      @(negedge clk); guard++;
    end
    while (lineOe && lineOut) begin
      holdLen++; @(negedge clk);
    end
    while (lineOe && !lineOut) begin
      lowLen++; @(negedge clk);
    end
    check(holdLen == 2 * bl, "R6 hold length", holdLen, 2 * bl);
    check(lowLen == 10 * bl, "R6 echo length", lowLen, 10 * bl);
    check(lineOe == 1'b0, "R6 released after echo", lineOe, 0);
  endtask

  initial begin
    logic [7:0] g; logic s; int sl; logic oa; int v0; int e0;
    doReset(1'b0, 1'b0);
    // R11 reset state
    check(lineOe == 1'b0 && txReady == 1'b1 && rxValid == 1'b0 && rxFrameErr == 1'b0,
          "R11 reset outputs", {lineOe, txReady, rxValid, rxFrameErr}, 4'b0100);

    // R1 transmit framing
    txCapture(8'hA5, DL, g, s, sl, oa);
    check(g == 8'hA5, "R1 data A5", g, 8'hA5);
    check(s == 1'b1, "R1 stop bit", s, 1);
    check(oa == 1'b0, "R8 released after tx", oa, 0);
    repeat (3) @(negedge clk);
    txCapture(8'h01, DL, g, s, sl, oa);
    check(g == 8'h01 && sl == DL, "R1 data 01", g, 8'h01);
    repeat (3) @(negedge clk);
    // R3 short ratio
    ratioCheck(DL, "R3 short bit period");

    // R2 receive, R8 port stays released, R9 request dropped while busy
    v0 = validCnt;
    fork
      sendChar(8'h3C, 1'b1, DL);
      begin
        repeat (4 * DL) @(negedge clk);
        check(txReady == 1'b0, "R9 not ready while receiving", txReady, 0);
        check(lineOe == 1'b0, "R8 released while receiving", lineOe, 0);
        txData = 8'h77; txValid = 1'b1;
        @(negedge clk);
        txValid = 1'b0;
        repeat (DL) @(negedge clk);
        check(lineOe == 1'b0, "R9 busy request dropped", lineOe, 0);
      end
    join
    repeat (DL) @(negedge clk);
    check(validCnt == v0 + 1 && lastByte == 8'h3C, "R2 byte 3C", lastByte, 8'h3C);
    check(lineOe == 1'b0 && txReady == 1'b1, "R9 idle after rx", lineOe, 0);
    sendChar(8'hC3, 1'b1, DL);
    repeat (DL) @(negedge clk);
    check(validCnt == v0 + 2 && lastByte == 8'hC3, "R2 byte C3", lastByte, 8'hC3);

    // R7 framing error
    v0 = validCnt; e0 = errCnt;
    sendChar(8'h5A, 1'b0, DL);
    repeat (DL) @(negedge clk);
    check(errCnt == e0 + 1, "R7 error pulse", errCnt - e0, 1);
    check(validCnt == v0, "R7 no valid", validCnt - v0, 0);
    check(lineOe == 1'b0, "R7 no reply", lineOe, 0);

    // R10 short glitch
    v0 = validCnt; e0 = errCnt;
    @(negedge clk);
    extLine = 1'b0;
    repeat (DL / 4) @(negedge clk);
    extLine = 1'b1;
    repeat (12 * DL) @(negedge clk);
    check(validCnt == v0 && errCnt == e0, "R10 glitch ignored",
          validCnt - v0 + errCnt - e0, 0);
    check(txReady == 1'b1, "R10 idle after glitch", txReady, 1);

    // R6 break reply
    v0 = validCnt; e0 = errCnt;
    fork
      sendChar(8'h00, 1'b0, DL);
      breakWatch(DL);
    join
    repeat (4) @(negedge clk);
    check(validCnt == v0 && errCnt == e0, "R6 break not a byte",
          validCnt - v0 + errCnt - e0, 0);

    // R5 strap change after reset has no effect
    selHigh = 1'b1; hvEntry = 1'b1;
    repeat (3) @(negedge clk);
    ratioCheck(DL, "R5 ratio kept after strap change");

    // R3 long ratio
    doReset(1'b1, 1'b0);
    ratioCheck(DH, "R3 long bit period");
    v0 = validCnt;
    sendChar(8'h96, 1'b1, DH);
    repeat (DH) @(negedge clk);
    check(validCnt == v0 + 1 && lastByte == 8'h96, "R2 byte at long ratio", lastByte, 8'h96);

    // R4 forcing input
    doReset(1'b0, 1'b1);
    ratioCheck(DH, "R4 forced long period");
    doReset(1'b1, 1'b1);
    ratioCheck(DH, "R4 forced with strap high");
    doReset(1'b0, 1'b0);
    ratioCheck(DL, "R3 back to short period");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule